// File: doc/BRIEF.md
# Addressed SPI Slave Front End with Hold

This block is the serial front end of a multi-channel register device that sits on a shared SPI bus. A system clock oversamples the bus lines (serial clock, active-low chip select, active-low hold, serial data in) through synchronizers. Inside the block the lines become qualified serial clock edges, and bytes are assembled most significant bit first. The first byte of every transaction is a slave address. Its upper six bits must equal a fixed identifier parameter and its two low bits must equal two strap inputs, so up to four devices can share one bus. When the address matches, the next byte is reported as an opcode and every byte after it as a write-data byte, each with a one-cycle strobe. At the start of each data byte a read byte is taken from the core and shifted out on the serial data output.

The block is held silent after power-up until chip select has made a high-to-low transition. A hold pause, taken while the serial clock is low, freezes the bit count and the partial byte until hold is released. Raising chip select ends a transaction at any point and discards any partial byte. The output tristate is modelled as an output-enable signal. Decoding of the opcode and the register bank lie outside this block.

Top module: `spi_addr_slave`

## Requirements
- R1: After reset, sdo_oe_o and addr_match_o are 0 and neither op_valid_o nor wr_valid_o pulses.
- R2: Serial data in is sampled on rising serial clock edges, most significant bit first. The second byte of a matched transaction appears on op_byte_o together with a single one-cycle op_valid_o pulse.
- R3: Every byte after the opcode byte of a matched transaction appears on wr_byte_o together with its own one-cycle wr_valid_o pulse.
- R4: The address byte matches when bits 7:2 equal DEV_ID (default 6'b010100, so addresses 0x50 to 0x53) and bits 1:0 equal strap_i. A match sets addr_match_o. A mismatch leaves addr_match_o at 0, and no strobe or output enable occurs for the rest of that transaction.
- R5: In the data phase of a matched transaction, rd_byte_i is captured at the first falling serial clock edge of each byte. It is driven out most significant bit first, with sdo_o changing only after falling edges, so that each bit is valid at the following rising edge.
- R6: sdo_oe_o is 0 while chip select is high, while a hold pause is active, and whenever the address did not match.
- R7: From reset until the first high-to-low transition of chip select, all bus activity is ignored, even if chip select is already low.
- R8: Hold going low while the serial clock is low pauses the transfer: serial clock edges are ignored and the bit count and partial byte are kept. Hold going high while the serial clock is low resumes the transfer where it stopped.
- R9: A rising edge of chip select discards any partial byte, clears addr_match_o and returns the block to awaiting an address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock, idle low |
| csn_i | input | 1 | Active-low chip select |
| holdn_i | input | 1 | Active-low hold pause |
| sdi_i | input | 1 | Serial data in |
| strap_i | input | 2 | Address strap pins compared with address bits 1:0 |
| rd_byte_i | input | 8 | Read byte from the core, captured at each data byte start |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Output enable for sdo_o (0 means high impedance) |
| addr_match_o | output | 1 | Address byte of the current transaction matched |
| op_valid_o | output | 1 | One-cycle strobe for a completed opcode byte |
| op_byte_o | output | 8 | Last received opcode byte |
| wr_valid_o | output | 1 | One-cycle strobe for a completed data byte |
| wr_byte_o | output | 8 | Last received data byte |

## Verification
The assertions assume that every level of the serial clock lasts longer than the synchronizer depth plus one system clock, so that no edge is lost. They also assume that hold changes only while the serial clock is low, that the strap pins are static during a transaction, and that rd_byte_i is stable from the preceding byte boundary through the first falling edge of the byte. The stimulus keeps each serial clock half period at six system clocks. It changes serial data and hold only in the low phase of the serial clock, and it moves chip select only while the serial clock is low. It sets the straps and the read byte before the transaction starts.

// File: rtl/spi_addr_pkg.sv
package spi_addr_pkg;

  parameter int unsigned SPI_BYTE_W  = 8;
  parameter int unsigned SPI_STRAP_W = 2;
  localparam int unsigned SPI_ID_W   = SPI_BYTE_W - SPI_STRAP_W;
  localparam int unsigned SPI_CNT_W  = $clog2(SPI_BYTE_W);

  typedef logic [SPI_BYTE_W-1:0] spi_byte_t;
  typedef logic [SPI_CNT_W-1:0]  spi_cnt_t;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_OP   = 2'd1,
    PH_DATA = 2'd2
  } spi_phase_e;

  // Append one serial bit at the LSB end (MSB-first reception).
  function automatic spi_byte_t spi_shift_in(input spi_byte_t sh, input logic b);
    return {sh[SPI_BYTE_W-2:0], b};
  endfunction

  // Address byte hit test: upper bits against the id, low bits against straps.
  function automatic logic spi_addr_hit(input spi_byte_t          a,
                                        input logic [SPI_ID_W-1:0]    id,
                                        input logic [SPI_STRAP_W-1:0] strap);
    return (a[SPI_BYTE_W-1:SPI_STRAP_W] == id) && (a[SPI_STRAP_W-1:0] == strap);
  endfunction

  // Counter step with wrap at the byte boundary.
  function automatic spi_cnt_t spi_cnt_next(input spi_cnt_t c);
    return (c == spi_cnt_t'(SPI_BYTE_W-1)) ? '0 : c + spi_cnt_t'(1);
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_link_ctrl.sv
module spi_link_ctrl #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic holdn_i,
  input  logic sdi_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_rise_o,
  output logic active_o,
  output logic hold_o,
  output logic sdi_o
);

  // Bit order {sdi, holdn, csn, sck}. Chip select resets to "low" so that a
  // line already low at power-up is never seen as a falling edge.
  localparam logic [3:0] SYNC_RST = 4'b0100;

  logic [3:0] raw, syn;
  logic sck_s, csn_s, holdn_s;
  logic sck_prev_q, csn_prev_q, armed_q, hold_q;
  logic cs_fall;

  assign raw = {sdi_i, holdn_i, csn_i, sck_i};

  spi_in_sync #(.W(4), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign sck_s   = syn[0];
  assign csn_s   = syn[1];
  assign holdn_s = syn[2];
  assign sdi_o   = syn[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q <= 1'b0;
      csn_prev_q <= 1'b0;
      armed_q    <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      sck_prev_q <= sck_s;
      csn_prev_q <= csn_s;
      if (cs_fall) armed_q <= 1'b1;
      if (!sck_s)  hold_q  <= ~holdn_s;
    end
  end

  assign cs_fall    = csn_prev_q & ~csn_s;
  assign cs_rise_o  = ~csn_prev_q & csn_s;
  assign active_o   = armed_q & ~csn_s;
  assign hold_o     = hold_q;
  assign sck_rise_o = active_o & ~hold_q & sck_s & ~sck_prev_q;
  assign sck_fall_o = active_o & ~hold_q & ~sck_s & sck_prev_q;

  AST_HOLD_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q != $past(hold_q)) |-> !$past(sck_s)); // R8

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_addr_pkg::*;
#(
  parameter logic [SPI_ID_W-1:0] DEV_ID = 6'b010100
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   active_i,
  input  logic                   sck_rise_i,
  input  logic                   sdi_i,
  input  logic [SPI_STRAP_W-1:0] strap_i,
  output spi_cnt_t               bit_cnt_o,
  output spi_phase_e             phase_o,
  output logic                   match_o,
  output logic                   op_valid_o,
  output spi_byte_t              op_byte_o,
  output logic                   wr_valid_o,
  output spi_byte_t              wr_byte_o
);

  spi_cnt_t   bit_cnt_q;
  spi_byte_t  shreg_q, shreg_nxt;
  spi_phase_e phase_q;
  logic       match_q, reject_q, op_valid_q, wr_valid_q;
  spi_byte_t  op_q, wr_q;
  logic       take_bit, byte_done;

  assign take_bit  = active_i & sck_rise_i & ~reject_q;
  assign byte_done = take_bit & (bit_cnt_q == spi_cnt_t'(SPI_BYTE_W-1));
  assign shreg_nxt = spi_shift_in(shreg_q, sdi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      phase_q    <= PH_ADDR;
      match_q    <= 1'b0;
      reject_q   <= 1'b0;
      op_valid_q <= 1'b0;
      wr_valid_q <= 1'b0;
      op_q       <= '0;
      wr_q       <= '0;
    end else begin
      op_valid_q <= 1'b0;
      wr_valid_q <= 1'b0;
      if (!active_i) begin
        bit_cnt_q <= '0;
        shreg_q   <= '0;
        phase_q   <= PH_ADDR;
        match_q   <= 1'b0;
        reject_q  <= 1'b0;
      end else if (take_bit) begin
        shreg_q   <= shreg_nxt;
        bit_cnt_q <= spi_cnt_next(bit_cnt_q);
        if (byte_done) begin
          unique case (phase_q)
            PH_ADDR: begin
              if (spi_addr_hit(shreg_nxt, DEV_ID, strap_i)) begin
                match_q <= 1'b1;
                phase_q <= PH_OP;
              end else begin
                reject_q <= 1'b1;
              end
            end
            PH_OP: begin
              op_q       <= shreg_nxt;
              op_valid_q <= 1'b1;
              phase_q    <= PH_DATA;
            end
            default: begin
              wr_q       <= shreg_nxt;
              wr_valid_q <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign bit_cnt_o  = bit_cnt_q;
  assign phase_o    = phase_q;
  assign match_o    = match_q;
  assign op_valid_o = op_valid_q;
  assign op_byte_o  = op_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_byte_o  = wr_q;

  AST_OP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_q |=> !op_valid_q); // R2

  AST_WR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_q |=> !wr_valid_q); // R3

  AST_WR_NEEDS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_q |-> match_q); // R4

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter
  import spi_addr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      active_i,
  input  logic      sck_fall_i,
  input  logic      data_ph_i,
  input  spi_cnt_t  bit_cnt_i,
  input  spi_byte_t rd_byte_i,
  output logic      sdo_o
);

  logic                  so_q;
  logic [SPI_BYTE_W-2:0] rest_q;
  logic                  load_now, shift_now;

  assign load_now  = active_i & sck_fall_i & data_ph_i & (bit_cnt_i == '0);
  assign shift_now = active_i & sck_fall_i & data_ph_i & (bit_cnt_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      so_q   <= 1'b0;
      rest_q <= '0;
    end else if (!active_i) begin
      so_q   <= 1'b0;
      rest_q <= '0;
    end else if (load_now) begin
      so_q   <= rd_byte_i[SPI_BYTE_W-1];
      rest_q <= rd_byte_i[SPI_BYTE_W-2:0];
    end else if (shift_now) begin
      so_q   <= rest_q[SPI_BYTE_W-2];
      rest_q <= {rest_q[SPI_BYTE_W-3:0], 1'b0};
    end
  end

  assign sdo_o = so_q;

  AST_SO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !sck_fall_i) |=> $stable(so_q)); // R5

endmodule

// File: rtl/spi_addr_slave.sv
module spi_addr_slave
  import spi_addr_pkg::*;
#(
  parameter int unsigned         SYNC_STAGES = 2,
  parameter logic [SPI_ID_W-1:0] DEV_ID      = 6'b010100
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sck_i,
  input  logic                   csn_i,
  input  logic                   holdn_i,
  input  logic                   sdi_i,
  input  logic [SPI_STRAP_W-1:0] strap_i,
  input  logic [SPI_BYTE_W-1:0]  rd_byte_i,
  output logic                   sdo_o,
  output logic                   sdo_oe_o,
  output logic                   addr_match_o,
  output logic                   op_valid_o,
  output logic [SPI_BYTE_W-1:0]  op_byte_o,
  output logic                   wr_valid_o,
  output logic [SPI_BYTE_W-1:0]  wr_byte_o
);

  logic       sck_rise, sck_fall, cs_rise, active, hold, sdi_s;
  spi_cnt_t   bit_cnt;
  spi_phase_e phase;
  logic       match, data_ph;

  spi_link_ctrl #(.STAGES(SYNC_STAGES)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_i     (sck_i),
    .csn_i     (csn_i),
    .holdn_i   (holdn_i),
    .sdi_i     (sdi_i),
    .sck_rise_o(sck_rise),
    .sck_fall_o(sck_fall),
    .cs_rise_o (cs_rise),
    .active_o  (active),
    .hold_o    (hold),
    .sdi_o     (sdi_s)
  );

  spi_byte_engine #(.DEV_ID(DEV_ID)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .sck_rise_i(sck_rise),
    .sdi_i     (sdi_s),
    .strap_i   (strap_i),
    .bit_cnt_o (bit_cnt),
    .phase_o   (phase),
    .match_o   (match),
    .op_valid_o(op_valid_o),
    .op_byte_o (op_byte_o),
    .wr_valid_o(wr_valid_o),
    .wr_byte_o (wr_byte_o)
  );

  assign data_ph = match & (phase == PH_DATA);

  spi_tx_shifter u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .sck_fall_i(sck_fall),
    .data_ph_i (data_ph),
    .bit_cnt_i (bit_cnt),
    .rd_byte_i (rd_byte_i),
    .sdo_o     (sdo_o)
  );

  assign sdo_oe_o     = active & data_ph & ~hold;
  assign addr_match_o = match;

  AST_OP_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> $past(active)); // R7

  AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> (bit_cnt == '0) && !match); // R9

  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold && active) |=> $stable(bit_cnt) && $stable(phase)); // R8

  AST_OE_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold || csn_i == 1'b1 && !active) |-> !sdo_oe_o); // R6

endmodule

// File: tb/spi_addr_slave_tb.sv
`timescale 1ns/1ps
module spi_addr_slave_tb_top;

  localparam int HALF = 6;
  localparam int NV   = 6;
  // {strap[1:0], addr[7:0], op[7:0], wr[7:0], expect_match}
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 8'h50, 8'hA5, 8'h3C, 1'b1},
    {2'd1, 8'h51, 8'h0F, 8'hC3, 1'b1},
    {2'd2, 8'h52, 8'h80, 8'h01, 1'b1},
    {2'd3, 8'h53, 8'h7E, 8'hFF, 1'b1},
    {2'd0, 8'h51, 8'h11, 8'h22, 1'b0},
    {2'd2, 8'hD2, 8'h33, 8'h44, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b0, holdn = 1'b1, sdi = 1'b0;
  logic [1:0] strap = 2'd0;
  logic [7:0] rd_byte = 8'h00;
  logic sdo, sdo_oe, match, op_valid, wr_valid;
  logic [7:0] op_byte, wr_byte;

  int n_chk = 0, n_fail = 0;
  int op_cnt = 0, wr_cnt = 0;
  logic [7:0] last_op = 8'h00, last_wr = 8'h00;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_addr_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .holdn_i(holdn),
    .sdi_i(sdi), .strap_i(strap), .rd_byte_i(rd_byte), .sdo_o(sdo),
    .sdo_oe_o(sdo_oe), .addr_match_o(match), .op_valid_o(op_valid),
    .op_byte_o(op_byte), .wr_valid_o(wr_valid), .wr_byte_o(wr_byte)
  );

  always @(negedge clk) begin
    if (op_valid) begin op_cnt++; last_op = op_byte; end
    if (wr_valid) begin wr_cnt++; last_wr = wr_byte; end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int hi, input int lo,
                           output logic [7:0] rx, output logic oe_any);
    rx = 8'h00; oe_any = 1'b0;
    for (int i = hi; i >= lo; i--) begin
      sdi = b[i];
      wait_clk(HALF);
      rx[i] = sdo;
      oe_any = oe_any | sdo_oe;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cs_on();
    csn = 1'b0; wait_clk(HALF);
  endtask

  task automatic cs_off();
    wait_clk(HALF); csn = 1'b1; wait_clk(2*HALF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rx, rx2;
    logic oe, oe2;
    int op0, wr0;

    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1 reset state
    check("R1 oe", sdo_oe, 0);
    check("R1 match", match, 0);
    check("R1 strobes", op_cnt + wr_cnt, 0);

    // R7 csn low since reset: transaction must be ignored
    send_bits(8'h50, 7, 0, rx, oe);
    check("R7 no match before arming", match, 0);
    send_bits(8'hC9, 7, 0, rx, oe);
    send_bits(8'h12, 7, 0, rx, oe);
    wait_clk(4);
    check("R7 no strobes before arming", op_cnt + wr_cnt, 0);
    check("R7 no oe before arming", oe, 0);
    cs_off();
    check("R6 oe low with cs high", sdo_oe, 0);

    // Vector table: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      strap   = VEC[v][26:25];
      rd_byte = VEC[v][16:9] ^ 8'h96;
      op0 = op_cnt; wr0 = wr_cnt;
      cs_on();
      send_bits(VEC[v][24:17], 7, 0, rx, oe);
      wait_clk(4);
      check($sformatf("R4 match vec%0d", v), match, VEC[v][0]);
      send_bits(VEC[v][16:9], 7, 0, rx, oe);
      send_bits(VEC[v][8:1], 7, 0, rx, oe);
      wait_clk(4);
      if (VEC[v][0]) begin
        check($sformatf("R2 op count vec%0d", v), op_cnt - op0, 1);
        check($sformatf("R2 op byte vec%0d", v), last_op, VEC[v][16:9]);
        check($sformatf("R3 wr byte vec%0d", v), last_wr, VEC[v][8:1]);
        check($sformatf("R5 read byte vec%0d", v), rx, VEC[v][16:9] ^ 8'h96);
        check($sformatf("R6 oe in data vec%0d", v), oe, 1);
      end else begin
        check($sformatf("R4 no strobes vec%0d", v), (op_cnt - op0) + (wr_cnt - wr0), 0);
        check($sformatf("R6 oe on mismatch vec%0d", v), oe, 0);
      end
      cs_off();
    end

    // R8 hold mid-opcode, then two data bytes (R3, R5)
    strap = 2'd1; rd_byte = 8'hB4;
    op0 = op_cnt; wr0 = wr_cnt;
    cs_on();
    send_bits(8'h51, 7, 0, rx, oe);
    send_bits(8'h6D, 7, 4, rx, oe);
    holdn = 1'b0;
    wait_clk(HALF);
    send_bits(8'hFF, 7, 0, rx, oe);
    send_bits(8'h00, 7, 5, rx, oe);
    wait_clk(4);
    check("R8 no op during hold", op_cnt - op0, 0);
    holdn = 1'b1;
    wait_clk(HALF);
    send_bits(8'h6D, 3, 0, rx, oe);
    wait_clk(4);
    check("R8 op resumes intact", last_op, 8'h6D);
    send_bits(8'h9A, 7, 0, rx, oe);
    rd_byte = 8'h4E;
    send_bits(8'h27, 7, 0, rx2, oe2);
    wait_clk(4);
    check("R3 two data strobes", wr_cnt - wr0, 2);
    check("R3 second data byte", last_wr, 8'h27);
    check("R5 first read byte", rx, 8'hB4);
    check("R5 second read byte", rx2, 8'h4E);
    // R6 hold in data phase drops oe
    holdn = 1'b0;
    wait_clk(HALF);
    check("R6 oe low in hold", sdo_oe, 0);
    holdn = 1'b1;
    wait_clk(HALF);
    check("R6 oe back after hold", sdo_oe, 1);
    cs_off();

    // R9 abort partial byte
    strap = 2'd0;
    cs_on();
    send_bits(8'h50, 7, 0, rx, oe);
    send_bits(8'hFF, 7, 5, rx, oe);
    cs_off();
    check("R9 match cleared", match, 0);
    cs_on();
    send_bits(8'h50, 7, 0, rx, oe);
    send_bits(8'h3A, 7, 0, rx, oe);
    wait_clk(4);
    check("R9 fresh opcode after abort", last_op, 8'h3A);
    cs_off();

    finish_run();
  end

endmodule